// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from memory to a MAC-side byte stream under the control of a small ring of transmit descriptors. Each descriptor holds a 16-bit status word, a 16-bit byte count and a buffer pointer. Software fills a descriptor through a single-cycle host write port and hands it over by setting its ready flag. The engine then reads the buffer one byte per accepted transfer from a simple memory read port. When the buffer has been sent, the engine clears the ready flag and writes the outcome into the status word, which gives the descriptor back to software.

The engine wakes up halted and touches nothing until a clear-halt command arrives. It walks the descriptors in index order. It returns to descriptor 0 after a descriptor carrying the wrap flag, or after the last physical descriptor. When it meets a descriptor that software has not made ready, it halts again. A graceful-stop command lets the frame in flight finish, then halts the engine and raises a stop-complete flag. Framing, preamble and CRC generation belong to the MAC. The engine only marks the final byte of a frame and tells the MAC whether to append a CRC.

Host word layout: the address is `{descriptor index, word select}`. Word select 0 is `{status[15:0], length[15:0]}`, and word select 1 is the buffer pointer, zero-extended. Status bits: 15 ready, 13 wrap, 12 interrupt-on-completion, 11 last-of-frame, 10 append-CRC, 1 fetch error, 0 empty buffer.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset the engine is halted, `tx_valid`, `tx_irq` and `stop_done` are 0, and every descriptor word reads back as 0.
- R2: While halted the engine issues no memory read and no byte. Only a `cmd_clear_halt` pulse takes it out of the halted state.
- R3: A ready descriptor with length N sends the N bytes at addresses pointer..pointer+N-1 in ascending order. A byte presented while `mac_ready` is 0 stays unchanged until it is accepted.
- R4: `tx_last` marks only the final byte of a descriptor whose status bit 11 is set, and `tx_crc` is raised with it only when status bit 10 is also set. A frame that spans several descriptors carries no end mark on its earlier descriptors.
- R5: On completion the engine clears status bit 15 and keeps the other flags and the length. Bits 1 and 0 read 0 after an error-free send.
- R6: After a descriptor whose status bit 13 is set, the next descriptor fetched is descriptor 0. After the last physical descriptor, the next one fetched is also descriptor 0.
- R7: Reaching a descriptor with status bit 15 clear halts the engine, which then stays halted until the next `cmd_clear_halt`.
- R8: A `cmd_graceful_stop` pulse lets the current frame finish through its last-of-frame descriptor, then halts the engine with `stop_done` set. The next `cmd_clear_halt` clears `stop_done`.
- R9: If `mem_err` is high during any byte fetch of a descriptor, status bit 1 is set in that descriptor's writeback, and all of its bytes are still sent.
- R10: A ready descriptor of length 0 sends no byte and is written back with bit 15 clear and bit 0 set.
- R11: Completing a descriptor whose status bit 12 is set gives a single one-cycle `tx_irq` pulse. No other descriptor produces a pulse.
- R12: If `cmd_clear_halt` and `cmd_graceful_stop` arrive in the same cycle while the engine is halted and not inside a frame, no byte is sent, `stop_done` is set, and the waiting descriptor stays ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Single-cycle host write strobe |
| host_addr | input | $clog2(NUM_DESC)+1 | Descriptor index and word select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational readback of the addressed word |
| cmd_clear_halt | input | 1 | Pulse: leave the halted state |
| cmd_graceful_stop | input | 1 | Pulse: stop at the next frame boundary |
| mem_rd | output | 1 | Memory byte fetch strobe |
| mem_addr | output | PTR_W | Byte address of the fetch |
| mem_rdata | input | 8 | Fetched byte, same cycle |
| mem_err | input | 1 | Fetch error flag, same cycle |
| tx_data | output | 8 | Byte toward the MAC |
| tx_valid | output | 1 | Byte is valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_crc | output | 1 | MAC should append a CRC after this frame |
| mac_ready | input | 1 | MAC accepts the byte this cycle |
| tx_irq | output | 1 | Completion pulse for descriptors that request it |
| halted | output | 1 | Engine is halted |
| stop_done | output | 1 | Graceful stop has completed |

## Verification
The two commands can coincide: a clear-halt that starts fetching, and a graceful stop that asks for a halt at the next boundary. The bench provokes this by pulsing both in one cycle while a ready descriptor waits. The result counts as correct only if no byte appears, `stop_done` rises, the descriptor still reads back as ready, and a later lone clear-halt sends exactly its bytes. The byte streams are swept over lengths 1 to 6 under three `mac_ready` patterns, and each stream is compared with bytes computed from the buffer addresses.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

   // status bit positions, decoded by software
   localparam int ST_READY    = 15;
   localparam int ST_WRAP     = 13;
   localparam int ST_IRQ      = 12;
   localparam int ST_LAST     = 11;
   localparam int ST_CRC      = 10;
   localparam int ST_UNDERRUN = 1;
   localparam int ST_EMPTY    = 0;

   typedef logic [15:0] stat_t;
   typedef logic [15:0] len_t;

   localparam stat_t M_READY    = stat_t'(1) << ST_READY;
   localparam stat_t M_WRAP     = stat_t'(1) << ST_WRAP;
   localparam stat_t M_IRQ      = stat_t'(1) << ST_IRQ;
   localparam stat_t M_LAST     = stat_t'(1) << ST_LAST;
   localparam stat_t M_CRC      = stat_t'(1) << ST_CRC;
   localparam stat_t M_UNDERRUN = stat_t'(1) << ST_UNDERRUN;
   localparam stat_t M_EMPTY    = stat_t'(1) << ST_EMPTY;
   localparam stat_t M_WB_CLR   = M_READY | M_UNDERRUN | M_EMPTY;

   typedef enum logic [2:0] {
      S_HALT,
      S_FETCH,
      S_SEND,
      S_DRAIN,
      S_WB
   } eng_state_e;

endpackage

// File: rtl/tx_desc_store.sv
module tx_desc_store
   import tx_ring_pkg::*;
#(
   parameter int NUM_DESC = 2,
   parameter int PTR_W    = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        host_we,
   input  logic [$clog2(NUM_DESC):0]   host_addr,
   input  logic [31:0]                 host_wdata,
   output logic [31:0]                 host_rdata,
   input  logic [$clog2(NUM_DESC)-1:0] eng_idx,
   output stat_t                       eng_stat,
   output len_t                        eng_len,
   output logic [PTR_W-1:0]            eng_ptr,
   input  logic                        wb_en,
   input  stat_t                       wb_stat
);

   localparam int IDX_W = $clog2(NUM_DESC);

   logic [IDX_W-1:0] host_idx;
   logic             host_sel;

   stat_t            stat_a [NUM_DESC];
   len_t             len_a  [NUM_DESC];
   logic [PTR_W-1:0] ptr_a  [NUM_DESC];

   assign host_idx = host_addr[IDX_W:1];
   assign host_sel = host_addr[0];

   for (genvar g = 0; g < NUM_DESC; g++) begin : g_ent
      stat_t            st_q;
      len_t             ln_q;
      logic [PTR_W-1:0] pt_q;
      logic             hit;
      logic             eng_hit;

      assign hit     = host_we && (host_idx == IDX_W'(g));
      assign eng_hit = wb_en && (eng_idx == IDX_W'(g));

      // host write has priority over the engine writeback
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q <= '0;
            ln_q <= '0;
            pt_q <= '0;
         end else begin
            if (hit && !host_sel) begin
               st_q <= host_wdata[31:16];
               ln_q <= host_wdata[15:0];
            end else if (eng_hit) begin
               st_q <= wb_stat;
            end
            if (hit && host_sel) begin
               pt_q <= host_wdata[PTR_W-1:0];
            end
         end
      end

      assign stat_a[g] = st_q;
      assign len_a[g]  = ln_q;
      assign ptr_a[g]  = pt_q;
   end

   always_comb begin
      host_rdata = '0;
      if (int'(host_idx) < NUM_DESC) begin
         if (host_sel) host_rdata = 32'(ptr_a[host_idx]);
         else          host_rdata = {stat_a[host_idx], len_a[host_idx]};
      end
   end

   assign eng_stat = stat_a[eng_idx];
   assign eng_len  = len_a[eng_idx];
   assign eng_ptr  = ptr_a[eng_idx];

endmodule

// File: rtl/tx_ring_ctrl.sv
module tx_ring_ctrl
   import tx_ring_pkg::*;
#(
   parameter int NUM_DESC = 2,
   parameter int PTR_W    = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_clear_halt,
   input  logic                        cmd_graceful_stop,
   output logic [$clog2(NUM_DESC)-1:0] eng_idx,
   input  stat_t                       eng_stat,
   input  len_t                        eng_len,
   input  logic [PTR_W-1:0]            eng_ptr,
   output logic                        wb_en,
   output stat_t                       wb_stat,
   output logic                        mem_rd,
   output logic [PTR_W-1:0]            mem_addr,
   input  logic [7:0]                  mem_rdata,
   input  logic                        mem_err,
   input  logic                        mac_ready,
   output logic [7:0]                  tx_data,
   output logic                        tx_valid,
   output logic                        tx_last,
   output logic                        tx_crc,
   output logic                        tx_irq,
   output logic                        halted,
   output logic                        stop_done
);

   localparam int IDX_W = $clog2(NUM_DESC);

   eng_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   len_t             cnt_q;
   stat_t            err_q;
   logic             stop_req_q;
   logic             in_frame_q;

   logic slot_free;
   logic final_byte;
   logic last_idx;

   assign slot_free  = !tx_valid || mac_ready;
   assign final_byte = (cnt_q == eng_len - 16'd1);
   assign last_idx   = (idx_q == IDX_W'(NUM_DESC - 1));

   assign eng_idx  = idx_q;
   assign mem_rd   = (state_q == S_SEND) && slot_free;
   assign mem_addr = eng_ptr + PTR_W'(cnt_q);
   assign wb_en    = (state_q == S_WB);
   assign wb_stat  = (eng_stat & ~M_WB_CLR) | err_q;
   assign halted   = (state_q == S_HALT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= S_HALT;
         idx_q      <= '0;
         cnt_q      <= '0;
         err_q      <= '0;
         stop_req_q <= 1'b0;
         in_frame_q <= 1'b0;
         tx_data    <= '0;
         tx_valid   <= 1'b0;
         tx_last    <= 1'b0;
         tx_crc     <= 1'b0;
         tx_irq     <= 1'b0;
         stop_done  <= 1'b0;
      end else begin
         tx_irq <= 1'b0;
         if (cmd_graceful_stop) stop_req_q <= 1'b1;
         if (tx_valid && mac_ready) begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            tx_crc   <= 1'b0;
         end

         case (state_q)
            S_HALT: begin
               if (cmd_clear_halt) begin
                  state_q   <= S_FETCH;
                  stop_done <= 1'b0;
               end else if (stop_req_q) begin
                  stop_done  <= 1'b1;
                  stop_req_q <= 1'b0;
               end
            end
            S_FETCH: begin
               if (stop_req_q && !in_frame_q) begin
                  state_q    <= S_HALT;
                  stop_done  <= 1'b1;
                  stop_req_q <= 1'b0;
               end else if (!eng_stat[ST_READY]) begin
                  state_q <= S_HALT;
               end else if (eng_len == '0) begin
                  err_q   <= M_EMPTY;
                  state_q <= S_WB;
               end else begin
                  err_q   <= '0;
                  cnt_q   <= '0;
                  state_q <= S_SEND;
               end
            end
            S_SEND: begin
               if (slot_free) begin
                  tx_data  <= mem_rdata;
                  tx_valid <= 1'b1;
                  tx_last  <= final_byte && eng_stat[ST_LAST];
                  tx_crc   <= final_byte && eng_stat[ST_LAST] && eng_stat[ST_CRC];
                  if (mem_err) err_q <= err_q | M_UNDERRUN;
                  cnt_q <= cnt_q + 16'd1;
                  if (final_byte) state_q <= S_DRAIN;
               end
            end
            S_DRAIN: begin
               if (slot_free) state_q <= S_WB;
            end
            S_WB: begin
               tx_irq     <= eng_stat[ST_IRQ];
               in_frame_q <= !eng_stat[ST_LAST];
               idx_q      <= (eng_stat[ST_WRAP] || last_idx) ? '0 : idx_q + 1'b1;
               state_q    <= S_FETCH;
            end
            default: state_q <= S_HALT;
         endcase
      end
   end

endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
   import tx_ring_pkg::*;
#(
   parameter int NUM_DESC = 2,
   parameter int PTR_W    = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      host_we,
   input  logic [$clog2(NUM_DESC):0] host_addr,
   input  logic [31:0]               host_wdata,
   output logic [31:0]               host_rdata,
   input  logic                      cmd_clear_halt,
   input  logic                      cmd_graceful_stop,
   output logic                      mem_rd,
   output logic [PTR_W-1:0]          mem_addr,
   input  logic [7:0]                mem_rdata,
   input  logic                      mem_err,
   output logic [7:0]                tx_data,
   output logic                      tx_valid,
   output logic                      tx_last,
   output logic                      tx_crc,
   input  logic                      mac_ready,
   output logic                      tx_irq,
   output logic                      halted,
   output logic                      stop_done
);

   localparam int IDX_W = $clog2(NUM_DESC);

   if (NUM_DESC < 2) begin : g_bad_depth
      $error("tx_ring_engine: NUM_DESC must be at least 2");
   end
   if (PTR_W < 8 || PTR_W > 32) begin : g_bad_ptr
      $error("tx_ring_engine: PTR_W must lie in 8..32");
   end

   logic [IDX_W-1:0] eng_idx;
   stat_t            eng_stat;
   len_t             eng_len;
   logic [PTR_W-1:0] eng_ptr;
   logic             wb_en;
   stat_t            wb_stat;

   tx_desc_store #(
      .NUM_DESC (NUM_DESC),
      .PTR_W    (PTR_W)
   ) i_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .eng_idx    (eng_idx),
      .eng_stat   (eng_stat),
      .eng_len    (eng_len),
      .eng_ptr    (eng_ptr),
      .wb_en      (wb_en),
      .wb_stat    (wb_stat)
   );

   tx_ring_ctrl #(
      .NUM_DESC (NUM_DESC),
      .PTR_W    (PTR_W)
   ) i_ctrl (
      .clk               (clk),
      .rst_n             (rst_n),
      .cmd_clear_halt    (cmd_clear_halt),
      .cmd_graceful_stop (cmd_graceful_stop),
      .eng_idx           (eng_idx),
      .eng_stat          (eng_stat),
      .eng_len           (eng_len),
      .eng_ptr           (eng_ptr),
      .wb_en             (wb_en),
      .wb_stat           (wb_stat),
      .mem_rd            (mem_rd),
      .mem_addr          (mem_addr),
      .mem_rdata         (mem_rdata),
      .mem_err           (mem_err),
      .mac_ready         (mac_ready),
      .tx_data           (tx_data),
      .tx_valid          (tx_valid),
      .tx_last           (tx_last),
      .tx_crc            (tx_crc),
      .tx_irq            (tx_irq),
      .halted            (halted),
      .stop_done         (stop_done)
   );

endmodule

// File: rtl/tx_ring_engine_chk.sv
module tx_ring_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_clear_halt,
   input logic       mem_rd,
   input logic [7:0] tx_data,
   input logic       tx_valid,
   input logic       tx_last,
   input logic       tx_crc,
   input logic       mac_ready,
   input logic       tx_irq,
   input logic       halted,
   input logic       stop_done
);

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !mac_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last))
      else $error("p_hold_r3");

   p_crc_with_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_crc |-> tx_last && tx_valid)
      else $error("p_crc_with_last_r4");

   p_quiet_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_rd)
      else $error("p_quiet_halt_r2");

   p_leave_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halted) |-> $past(cmd_clear_halt))
      else $error("p_leave_halt_r7");

   p_stop_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_done) |-> halted)
      else $error("p_stop_halted_r8");

   p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |=> !tx_irq)
      else $error("p_irq_pulse_r11");

endmodule

bind tx_ring_engine tx_ring_engine_chk i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cmd_clear_halt (cmd_clear_halt),
   .mem_rd         (mem_rd),
   .tx_data        (tx_data),
   .tx_valid       (tx_valid),
   .tx_last        (tx_last),
   .tx_crc         (tx_crc),
   .mac_ready      (mac_ready),
   .tx_irq         (tx_irq),
   .halted         (halted),
   .stop_done      (stop_done)
);

// File: tb/test_tx_ring_engine.sv
module test_tx_ring_engine;
   import tx_ring_pkg::*;

   localparam int ND = 2;
   localparam int PW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_we = 1'b0;
   logic [1:0]    host_addr = '0;
   logic [31:0]   host_wdata = '0;
   logic [31:0]   host_rdata;
   logic          cmd_clear_halt = 1'b0;
   logic          cmd_graceful_stop = 1'b0;
   logic          mem_rd;
   logic [PW-1:0] mem_addr;
   logic [7:0]    mem_rdata;
   logic          mem_err;
   logic [7:0]    tx_data;
   logic          tx_valid, tx_last, tx_crc;
   logic          mac_ready;
   logic          tx_irq, halted, stop_done;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int mode = 0;
   int rd_seen = 0;
   int irq_seen = 0;
   int cur = 0;
   logic        err_en = 1'b0;
   logic [31:0] err_addr = '0;
   logic [9:0]  got_q[$];
   logic [9:0]  exp_q[$];

   always #5 clk = ~clk;

   tx_ring_engine #(.NUM_DESC(ND), .PTR_W(PW)) i_tx_ring_engine (
      .clk (clk), .rst_n (rst_n),
      .host_we (host_we), .host_addr (host_addr),
      .host_wdata (host_wdata), .host_rdata (host_rdata),
      .cmd_clear_halt (cmd_clear_halt), .cmd_graceful_stop (cmd_graceful_stop),
      .mem_rd (mem_rd), .mem_addr (mem_addr), .mem_rdata (mem_rdata), .mem_err (mem_err),
      .tx_data (tx_data), .tx_valid (tx_valid), .tx_last (tx_last), .tx_crc (tx_crc),
      .mac_ready (mac_ready), .tx_irq (tx_irq), .halted (halted), .stop_done (stop_done)
   );

   function automatic logic [7:0] mem_f(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   function automatic logic [31:0] w0(input stat_t s, input int len);
      return {s, 16'(len)};
   endfunction

   assign mem_rdata = mem_f(mem_addr);
   assign mem_err   = err_en && (mem_addr == err_addr);

   initial begin
      mac_ready = 1'b1;
      forever begin
         @(posedge clk);
         #2;
         cyc++;
         case (mode)
            0:       mac_ready = 1'b1;
            1:       mac_ready = cyc[0];
            default: mac_ready = (cyc % 3) != 0;
         endcase
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (tx_valid && mac_ready) got_q.push_back({tx_crc, tx_last, tx_data});
            if (mem_rd) rd_seen++;
            if (tx_irq) irq_seen++;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hwrite(input int idx, input int sel, input logic [31:0] d);
      @(negedge clk);
      host_we    = 1'b1;
      host_addr  = {1'(idx), 1'(sel)};
      host_wdata = d;
      @(negedge clk);
      host_we    = 1'b0;
   endtask

   task automatic hread(input int idx, input int sel, output logic [31:0] d);
      @(negedge clk);
      host_addr = {1'(idx), 1'(sel)};
      #1;
      d = host_rdata;
   endtask

   task automatic cmd(input logic c, input logic s);
      @(negedge clk);
      cmd_clear_halt    = c;
      cmd_graceful_stop = s;
      @(negedge clk);
      cmd_clear_halt    = 1'b0;
      cmd_graceful_stop = 1'b0;
   endtask

   task automatic wait_halt();
      repeat (3) @(negedge clk);
      for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
   endtask

   task automatic push_exp(input logic [31:0] base, input int len, input bit lst, input bit crc);
      for (int i = 0; i < len; i++) begin
         exp_q.push_back({(i == len - 1) && crc, (i == len - 1) && lst, mem_f(base + 32'(i))});
      end
   endtask

   task automatic cmp_stream(input string req);
      chk(got_q.size() == exp_q.size(), {req, " byte count"}, got_q.size(), exp_q.size());
      for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
         chk(got_q[i] == exp_q[i], {req, " byte"}, 32'(got_q[i]), 32'(exp_q[i]));
      end
      got_q.delete();
      exp_q.delete();
   endtask

   task automatic setup(input int idx, input logic [31:0] ptr, input stat_t s, input int len);
      hwrite(idx, 1, ptr);
      hwrite(idx, 0, w0(s, len));
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(halted == 1'b1, "R1 halted", 32'(halted), 1);
      chk(tx_valid == 1'b0 && tx_irq == 1'b0, "R1 outputs idle", 32'({tx_valid, tx_irq}), 0);
      chk(stop_done == 1'b0, "R1 stop_done", 32'(stop_done), 0);
      hread(0, 0, v); chk(v == 32'h0, "R1 desc0 word0", v, 0);
      hread(1, 1, v); chk(v == 32'h0, "R1 desc1 ptr", v, 0);

      // R2 nothing happens before clear-halt
      setup(0, 32'h0100, M_READY | M_LAST | M_CRC | M_IRQ, 5);
      repeat (20) @(negedge clk);
      chk(rd_seen == 0, "R2 no fetch while halted", rd_seen, 0);
      chk(got_q.size() == 0, "R2 no byte while halted", got_q.size(), 0);
      chk(halted == 1'b1, "R2 still halted", 32'(halted), 1);

      // first frame, then halt on the not-ready descriptor 1
      cmd(1'b1, 1'b0);
      wait_halt();
      push_exp(32'h0100, 5, 1'b1, 1'b1);
      cmp_stream("R3 R4 first frame");
      hread(0, 0, v); chk(v == w0(M_LAST | M_CRC | M_IRQ, 5), "R5 writeback desc0", v, w0(M_LAST | M_CRC | M_IRQ, 5));
      chk(irq_seen == 1, "R11 one irq pulse", irq_seen, 1);
      chk(halted == 1'b1, "R7 halted on not-ready", 32'(halted), 1);
      repeat (10) @(negedge clk);
      chk(halted == 1'b1 && got_q.size() == 0, "R7 stays halted", 32'(halted), 1);
      cur = 1;

      // sweep: lengths 1..6 under three backpressure patterns, ring walks 1,0,1,...
      for (int m = 0; m < 3; m++) begin
         for (int len = 1; len <= 6; len++) begin
            logic [31:0] base;
            mode = m;
            base = 32'h1000 + 32'(m) * 32'h100 + 32'(len) * 32'h10;
            setup(cur, base, M_READY | M_LAST | M_CRC, len);
            cmd(1'b1, 1'b0);
            wait_halt();
            push_exp(base, len, 1'b1, 1'b1);
            cmp_stream("R3 sweep");
            hread(cur, 0, v);
            chk(v == w0(M_LAST | M_CRC, len), "R5 R6 sweep writeback", v, w0(M_LAST | M_CRC, len));
            cur = cur ^ 1;
         end
      end
      mode = 0;
      chk(irq_seen == 1, "R11 no irq without flag", irq_seen, 1);

      // R9 fetch error on desc1
      err_en = 1'b1; err_addr = 32'h0302;
      setup(1, 32'h0300, M_READY | M_LAST, 4);
      cmd(1'b1, 1'b0);
      wait_halt();
      err_en = 1'b0;
      push_exp(32'h0300, 4, 1'b1, 1'b0);
      cmp_stream("R9 bytes still sent");
      hread(1, 0, v); chk(v == w0(M_LAST | M_UNDERRUN, 4), "R9 error bit", v, w0(M_LAST | M_UNDERRUN, 4));

      // R6 wrap flag on desc0 returns to desc0, desc1 untouched
      setup(1, 32'h2100, M_READY | M_LAST, 3);
      setup(0, 32'h2000, M_READY | M_LAST | M_WRAP, 2);
      cmd(1'b1, 1'b0);
      wait_halt();
      push_exp(32'h2000, 2, 1'b1, 1'b0);
      cmp_stream("R6 wrap");
      hread(1, 0, v); chk(v == w0(M_READY | M_LAST, 3), "R6 desc1 skipped", v, w0(M_READY | M_LAST, 3));
      hread(0, 0, v); chk(v == w0(M_LAST | M_WRAP, 2), "R6 desc0 written back", v, w0(M_LAST | M_WRAP, 2));
      hwrite(1, 0, 32'h0);

      // R4 frame across two descriptors
      setup(0, 32'h3000, M_READY, 3);
      setup(1, 32'h3100, M_READY | M_LAST | M_CRC, 2);
      mode = 1;
      cmd(1'b1, 1'b0);
      wait_halt();
      mode = 0;
      push_exp(32'h3000, 3, 1'b0, 1'b0);
      push_exp(32'h3100, 2, 1'b1, 1'b1);
      cmp_stream("R4 multi-descriptor");

      // R10 zero length on desc0
      setup(0, 32'h4000, M_READY | M_LAST, 0);
      cmd(1'b1, 1'b0);
      wait_halt();
      chk(got_q.size() == 0, "R10 no byte", got_q.size(), 0);
      hread(0, 0, v); chk(v == w0(M_LAST | M_EMPTY, 0), "R10 empty bit", v, w0(M_LAST | M_EMPTY, 0));
      got_q.delete();

      // R8 graceful stop mid frame: desc1 (open) then desc0 (last)
      setup(1, 32'h5000, M_READY, 4);
      setup(0, 32'h5100, M_READY | M_LAST, 4);
      cmd(1'b1, 1'b0);
      cmd(1'b0, 1'b1);
      wait_halt();
      push_exp(32'h5000, 4, 1'b0, 1'b0);
      push_exp(32'h5100, 4, 1'b1, 1'b0);
      cmp_stream("R8 frame finished");
      chk(stop_done == 1'b1, "R8 stop_done set", 32'(stop_done), 1);
      hread(0, 0, v); chk(v == w0(M_LAST, 4), "R8 last desc released", v, w0(M_LAST, 4));
      cmd(1'b1, 1'b0);
      wait_halt();
      chk(stop_done == 1'b0, "R8 clear-halt clears stop_done", 32'(stop_done), 0);

      // R12 clear-halt and graceful stop in the same cycle (engine at desc1)
      setup(1, 32'h6000, M_READY | M_LAST, 3);
      cmd(1'b1, 1'b1);
      wait_halt();
      chk(got_q.size() == 0, "R12 no byte", got_q.size(), 0);
      chk(stop_done == 1'b1, "R12 stop_done", 32'(stop_done), 1);
      hread(1, 0, v); chk(v == w0(M_READY | M_LAST, 3), "R12 desc still ready", v, w0(M_READY | M_LAST, 3));
      cmd(1'b1, 1'b0);
      wait_halt();
      push_exp(32'h6000, 3, 1'b1, 1'b0);
      cmp_stream("R12 later send");
      chk(stop_done == 1'b0, "R12 stop_done cleared", 32'(stop_done), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule